// File: doc/BRIEF.md
# Receive Security-Association Table Writer

This block holds the receive-side security-association tables of a packet engine: one table of IP addresses and two tables keyed by association number. The first of these holds the SPI together with a pointer into the address table. The second holds the cipher key, the salt and a mode word. Software never addresses table storage directly. It fills a bank of staging registers over a simple 32-bit register bus. It then writes a single command word that carries a lookup-enable bit, a table selector, an entry index and a read or write strobe. A write strobe copies the staged fields into the chosen entry. A read strobe copies the chosen entry back into the staging registers, where the bus can read it.

The tables have no reset. Their contents survive a reset, so software is expected to scrub every entry before it relies on them. The lookup-enable bit travels in every command word and is presented on `lookup_en` to gate the lookup logic downstream.

Top module: `sa_table_regs`

## Requirements
- R1: Staging registers sit at word addresses 1..4 (address words 0..3), 5 (SPI), 6 (address-table pointer, 7 bits kept), 7..10 (key words 0..3), 11 (salt) and 12 (mode). Each one reads back what was last written. The mode register keeps only bits 0 (valid), 2 (ESP), 3 (decrypt) and 4 (IPv6); every other mode bit reads as zero. Reset clears all staging registers to zero.
- R2: The command register sits at address 0. Its fields are: bit 0 enable, bits 2:1 table select, bits 12:3 entry index, bit 30 read strobe and bit 31 write strobe. Enable, select and index read back as written. Bits 30, 31 and all other bits always read as zero.
- R3: `lookup_en` takes bit 0 of the most recent command write from the clock edge that accepts that write, whether or not a strobe is set. Reset clears it.
- R4: A write strobe with select 01 copies the four staged address words into the address-table entry, keeping word positions unchanged, so an IPv4 address staged in word 3 returns in word 3. The copy happens at the edge after the command edge.
- R5: A write strobe with select 10 stores the staged SPI and the staged address-table pointer as one entry.
- R6: A write strobe with select 11 stores the four key words, the salt and the mode as one entry.
- R7: A read strobe loads the selected entry into the staging fields of that table only, at the edge after the command edge. Staging registers change at no other time except bus writes and reset.
- R8: An entry index at or beyond the depth of the selected table (128 for the address table, 1024 for the others) is ignored. A write modifies no entry, and a read leaves the staging registers unchanged.
- R9: Select 00 with either strobe performs no table access.
- R10: A command with both strobes set performs only the write.
- R11: Table contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of registers (not tables) |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lookup_en | output | 1 | Lookup-engine enable from command bit 0 |

## Verification
A bus write is taken at one rising edge. Staging registers and `lookup_en` hold the new value from that edge. A strobed table copy, in either direction, happens one edge later. `reg_rdata` follows `reg_addr` with no delay. Each command task in the bench therefore drives the write across one edge, waits one more full cycle for the copy, and only then samples read data half a cycle from any edge. The ignored-access cases (out-of-range index, select 00, both strobes) are judged by reading back the entries and staging registers they could have touched.

// File: rtl/sa_tbl_pkg.sv
package sa_tbl_pkg;

    // register word addresses
    localparam logic [3:0] A_CMD   = 4'd0;
    localparam logic [3:0] A_IP0   = 4'd1;
    localparam logic [3:0] A_SPI   = 4'd5;
    localparam logic [3:0] A_IPX   = 4'd6;
    localparam logic [3:0] A_KEY0  = 4'd7;
    localparam logic [3:0] A_SALT  = 4'd11;
    localparam logic [3:0] A_MODE  = 4'd12;

    // command word field positions
    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_SEL_LSB = 1;
    localparam int CMD_IDX_LSB = 3;
    localparam int CMD_IDX_W   = 10;
    localparam int CMD_RD_BIT  = 30;
    localparam int CMD_WR_BIT  = 31;

    localparam int WORD_W = 32;
    localparam int MODE_W = 5;
    localparam logic [MODE_W-1:0] MODE_KEEP = 5'b11101;

    typedef enum logic [1:0] {
        TSEL_NONE = 2'b00,
        TSEL_ADDR = 2'b01,
        TSEL_SPI  = 2'b10,
        TSEL_KEY  = 2'b11
    } tsel_e;

    typedef logic [3:0][WORD_W-1:0] quad_t;

    typedef struct packed {
        quad_t              key;
        logic [WORD_W-1:0]  salt;
        logic [MODE_W-1:0]  mode;
    } key_ent_t;

    typedef struct packed {
        logic                 en;
        tsel_e                sel;
        logic [CMD_IDX_W-1:0] idx;
        logic                 wr_pend;
        logic                 rd_pend;
    } cmd_state_t;

endpackage

// File: rtl/sa_entry_store.sv
module sa_entry_store #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    // no reset: contents persist across reset by design
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sa_cmd_ctrl.sv
module sa_cmd_ctrl
    import sa_tbl_pkg::*;
#(
    parameter int SA_DEPTH = 1024,
    parameter int IP_DEPTH = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic                 cmd_en,
    input  logic [1:0]           cmd_sel,
    input  logic [CMD_IDX_W-1:0] cmd_idx,
    input  logic                 cmd_rd_stb,
    input  logic                 cmd_wr_stb,
    output logic                 en,
    output tsel_e                sel,
    output logic [CMD_IDX_W-1:0] idx,
    output logic                 do_wr,
    output logic                 do_rd
);

    cmd_state_t s_d, s_q;
    logic       in_range;

    always_comb begin
        unique case (tsel_e'(cmd_sel))
            TSEL_ADDR: in_range = 32'(cmd_idx) < IP_DEPTH;
            TSEL_SPI,
            TSEL_KEY:  in_range = 32'(cmd_idx) < SA_DEPTH;
            default:   in_range = 1'b0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        s_d.wr_pend = 1'b0;
        s_d.rd_pend = 1'b0;
        if (cmd_wr) begin
            s_d.en      = cmd_en;
            s_d.sel     = tsel_e'(cmd_sel);
            s_d.idx     = cmd_idx;
            s_d.wr_pend = cmd_wr_stb && in_range;
            s_d.rd_pend = cmd_rd_stb && !cmd_wr_stb && in_range;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en    = s_q.en;
    assign sel   = s_q.sel;
    assign idx   = s_q.idx;
    assign do_wr = s_q.wr_pend;
    assign do_rd = s_q.rd_pend;

    AST_PEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.wr_pend && s_q.rd_pend)); // R10

    AST_PEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wr_pend || s_q.rd_pend) && !cmd_wr |=> !(s_q.wr_pend || s_q.rd_pend)); // R7

endmodule

// File: rtl/sa_table_regs.sv
module sa_table_regs
    import sa_tbl_pkg::*;
#(
    parameter int SA_DEPTH = 1024,
    parameter int IP_DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        lookup_en
);

    localparam int SA_AW  = $clog2(SA_DEPTH);
    localparam int IP_AW  = $clog2(IP_DEPTH);
    localparam int IPX_W  = IP_AW;
    localparam int SPI_EW = WORD_W + IPX_W;
    localparam int KEY_EW = $bits(key_ent_t);
    localparam int ADR_EW = $bits(quad_t);

    typedef struct packed {
        quad_t              ipw;
        logic [WORD_W-1:0]  spi;
        logic [IPX_W-1:0]   ipx;
        key_ent_t           ke;
    } stage_t;

    stage_t stg_d, stg_q;

    logic                 cmd_wr;
    logic                 c_en;
    tsel_e                c_sel;
    logic [CMD_IDX_W-1:0] c_idx;
    logic                 do_wr, do_rd;

    logic              ip_we, spi_we, key_we;
    logic [ADR_EW-1:0] ip_rdata;
    logic [SPI_EW-1:0] spi_rdata;
    logic [KEY_EW-1:0] key_rdata;

    assign cmd_wr = reg_wr && (reg_addr == A_CMD);

    sa_cmd_ctrl #(.SA_DEPTH(SA_DEPTH), .IP_DEPTH(IP_DEPTH)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_en     (reg_wdata[CMD_EN_BIT]),
        .cmd_sel    (reg_wdata[CMD_SEL_LSB +: 2]),
        .cmd_idx    (reg_wdata[CMD_IDX_LSB +: CMD_IDX_W]),
        .cmd_rd_stb (reg_wdata[CMD_RD_BIT]),
        .cmd_wr_stb (reg_wdata[CMD_WR_BIT]),
        .en         (c_en),
        .sel        (c_sel),
        .idx        (c_idx),
        .do_wr      (do_wr),
        .do_rd      (do_rd)
    );

    assign ip_we  = do_wr && (c_sel == TSEL_ADDR);
    assign spi_we = do_wr && (c_sel == TSEL_SPI);
    assign key_we = do_wr && (c_sel == TSEL_KEY);

    sa_entry_store #(.DEPTH(IP_DEPTH), .WIDTH(ADR_EW)) addr_tbl_i (
        .clk   (clk),
        .we    (ip_we),
        .waddr (c_idx[IP_AW-1:0]),
        .wdata (stg_q.ipw),
        .raddr (c_idx[IP_AW-1:0]),
        .rdata (ip_rdata)
    );

    sa_entry_store #(.DEPTH(SA_DEPTH), .WIDTH(SPI_EW)) spi_tbl_i (
        .clk   (clk),
        .we    (spi_we),
        .waddr (c_idx[SA_AW-1:0]),
        .wdata ({stg_q.spi, stg_q.ipx}),
        .raddr (c_idx[SA_AW-1:0]),
        .rdata (spi_rdata)
    );

    sa_entry_store #(.DEPTH(SA_DEPTH), .WIDTH(KEY_EW)) key_tbl_i (
        .clk   (clk),
        .we    (key_we),
        .waddr (c_idx[SA_AW-1:0]),
        .wdata (stg_q.ke),
        .raddr (c_idx[SA_AW-1:0]),
        .rdata (key_rdata)
    );

    // next staging value: table read-back first, then a bus write on top
    always_comb begin
        stg_d = stg_q;
        if (do_rd) begin
            unique case (c_sel)
                TSEL_ADDR: stg_d.ipw = ip_rdata;
                TSEL_SPI:  {stg_d.spi, stg_d.ipx} = spi_rdata;
                TSEL_KEY:  stg_d.ke = key_ent_t'(key_rdata);
                default:   ;
            endcase
        end
        if (reg_wr) begin
            for (int w = 0; w < 4; w++) begin
                if (reg_addr == A_IP0 + 4'(w)) begin
                    stg_d.ipw[w] = reg_wdata;
                end
                if (reg_addr == A_KEY0 + 4'(w)) begin
                    stg_d.ke.key[w] = reg_wdata;
                end
            end
            if (reg_addr == A_SPI) begin
                stg_d.spi = reg_wdata;
            end
            if (reg_addr == A_IPX) begin
                stg_d.ipx = reg_wdata[IPX_W-1:0];
            end
            if (reg_addr == A_SALT) begin
                stg_d.ke.salt = reg_wdata;
            end
            if (reg_addr == A_MODE) begin
                stg_d.ke.mode = reg_wdata[MODE_W-1:0] & MODE_KEEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < 4; w++) begin
            if (reg_addr == A_IP0 + 4'(w)) begin
                reg_rdata = stg_q.ipw[w];
            end
            if (reg_addr == A_KEY0 + 4'(w)) begin
                reg_rdata = stg_q.ke.key[w];
            end
        end
        unique case (reg_addr)
            A_CMD:   reg_rdata = {19'b0, c_idx, c_sel, c_en};
            A_SPI:   reg_rdata = stg_q.spi;
            A_IPX:   reg_rdata = 32'(stg_q.ipx);
            A_SALT:  reg_rdata = stg_q.ke.salt;
            A_MODE:  reg_rdata = 32'(stg_q.ke.mode);
            default: ;
        endcase
    end

    assign lookup_en = c_en;

    AST_EN_TRACKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> lookup_en == $past(reg_wdata[CMD_EN_BIT])); // R3

    AST_CMD_STROBES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == A_CMD |-> reg_rdata[31:30] == 2'b00); // R2

    AST_ADDR_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ip_we |-> 32'(c_idx) < IP_DEPTH); // R8

    AST_STAGE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr && !do_rd |=> $stable(stg_q)); // R7

endmodule

// File: tb/sa_table_regs_tb_top.sv
module sa_table_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lookup_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sa_table_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lookup_en (lookup_en)
    );

    localparam logic [1:0] S_NONE = 2'b00, S_ADDR = 2'b01, S_SPI = 2'b10, S_KEY = 2'b11;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_cmd(input bit en, input logic [1:0] sel,
                                            input int idx, input bit rd, input bit wr);
        return {wr, rd, 17'b0, idx[9:0], sel, en};
    endfunction

    // command write, then one idle cycle for the copy edge
    task automatic command(input logic [31:0] c);
        bus_write(4'd0, c);
        @(negedge clk);
    endtask

    task automatic stage_quad(input logic [3:0] base, input logic [31:0] w0, w1, w2, w3);
        bus_write(base, w0);
        bus_write(base + 4'd1, w1);
        bus_write(base + 4'd2, w2);
        bus_write(base + 4'd3, w3);
    endtask

    task automatic check_quad(input string req, input logic [3:0] base,
                              input logic [31:0] w0, w1, w2, w3);
        logic [31:0] r;
        bus_read(base, r);        check(req, r, w0);
        bus_read(base + 4'd1, r); check(req, r, w1);
        bus_read(base + 4'd2, r); check(req, r, w2);
        bus_read(base + 4'd3, r); check(req, r, w3);
    endtask

    task automatic t_reset_state();
        logic [31:0] r;
        check("R3 reset lookup_en", 32'(lookup_en), 32'd0);
        bus_read(4'd0, r);  check("R2 reset cmd", r, 32'd0);
        for (int a = 1; a <= 12; a++) begin
            bus_read(4'(a), r); check("R1 reset staging", r, 32'd0);
        end
    endtask

    task automatic t_staging_regs();
        logic [31:0] r;
        bus_write(4'd5, 32'hDEAD_BEEF);
        bus_read(4'd5, r);  check("R1 spi readback", r, 32'hDEAD_BEEF);
        bus_write(4'd6, 32'hFFFF_FFAB);
        bus_read(4'd6, r);  check("R1 pointer 7 bits", r, 32'h0000_002B);
        bus_write(4'd12, 32'hFFFF_FFFF);
        bus_read(4'd12, r); check("R1 mode mask", r, 32'h0000_001D);
        bus_write(4'd11, 32'h0BAD_5A17);
        bus_read(4'd11, r); check("R1 salt readback", r, 32'h0BAD_5A17);
    endtask

    task automatic t_cmd_and_enable();
        logic [31:0] r;
        bus_write(4'd0, mk_cmd(1'b1, S_NONE, 0, 1'b0, 1'b0));
        check("R3 enable set", 32'(lookup_en), 32'd1);
        command(mk_cmd(1'b1, S_KEY, 1000, 1'b1, 1'b0));
        bus_read(4'd0, r);
        check("R2 cmd fields, strobes zero", r, {19'b0, 10'd1000, S_KEY, 1'b1});
        bus_write(4'd0, mk_cmd(1'b0, S_NONE, 0, 1'b0, 1'b0));
        check("R3 enable cleared by plain write", 32'(lookup_en), 32'd0);
    endtask

    task automatic t_addr_table();
        stage_quad(4'd1, 32'h0, 32'h0, 32'h0, 32'hC0A8_0001);
        command(mk_cmd(1'b1, S_ADDR, 5, 1'b0, 1'b1));
        stage_quad(4'd1, 32'h2001_0DB8, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666);
        command(mk_cmd(1'b1, S_ADDR, 127, 1'b0, 1'b1));
        stage_quad(4'd1, '1, '1, '1, '1);
        command(mk_cmd(1'b1, S_ADDR, 5, 1'b1, 1'b0));
        check_quad("R4 IPv4 word 3", 4'd1, 32'h0, 32'h0, 32'h0, 32'hC0A8_0001);
        command(mk_cmd(1'b1, S_ADDR, 127, 1'b1, 1'b0));
        check_quad("R4 last entry", 4'd1, 32'h2001_0DB8, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666);
    endtask

    task automatic t_spi_table();
        logic [31:0] r;
        bus_write(4'd5, 32'h0000_1234);
        bus_write(4'd6, 32'd99);
        command(mk_cmd(1'b1, S_SPI, 1023, 1'b0, 1'b1));
        bus_write(4'd5, 32'h0);
        bus_write(4'd6, 32'h0);
        bus_write(4'd11, 32'h7777_7777);
        command(mk_cmd(1'b1, S_SPI, 1023, 1'b1, 1'b0));
        bus_read(4'd5, r);  check("R5 spi stored", r, 32'h0000_1234);
        bus_read(4'd6, r);  check("R5 pointer stored", r, 32'd99);
        bus_read(4'd11, r); check("R7 salt untouched by spi read", r, 32'h7777_7777);
    endtask

    task automatic t_key_table();
        logic [31:0] r;
        stage_quad(4'd7, 32'hA0A0_0001, 32'hA0A0_0002, 32'hA0A0_0003, 32'hA0A0_0004);
        bus_write(4'd11, 32'h5A17_0000);
        bus_write(4'd12, 32'h0000_000D);
        command(mk_cmd(1'b1, S_KEY, 3, 1'b0, 1'b1));
        stage_quad(4'd7, 0, 0, 0, 0);
        bus_write(4'd11, 0);
        bus_write(4'd12, 0);
        command(mk_cmd(1'b1, S_KEY, 3, 1'b1, 1'b0));
        check_quad("R6 key words", 4'd7, 32'hA0A0_0001, 32'hA0A0_0002, 32'hA0A0_0003, 32'hA0A0_0004);
        bus_read(4'd11, r); check("R6 salt", r, 32'h5A17_0000);
        bus_read(4'd12, r); check("R6 mode", r, 32'h0000_000D);
    endtask

    task automatic t_out_of_range();
        stage_quad(4'd1, 32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003, 32'hAAAA_0004);
        command(mk_cmd(1'b1, S_ADDR, 72, 1'b0, 1'b1));
        stage_quad(4'd1, 32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003, 32'hBBBB_0004);
        command(mk_cmd(1'b1, S_ADDR, 200, 1'b0, 1'b1));
        command(mk_cmd(1'b1, S_ADDR, 200, 1'b1, 1'b0));
        check_quad("R8 read beyond depth ignored", 4'd1,
                   32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003, 32'hBBBB_0004);
        command(mk_cmd(1'b1, S_ADDR, 72, 1'b1, 1'b0));
        check_quad("R8 write beyond depth ignored", 4'd1,
                   32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003, 32'hAAAA_0004);
    endtask

    task automatic t_select_none();
        logic [31:0] r;
        bus_write(4'd5, 32'h0000_1234);
        bus_write(4'd6, 32'd99);
        bus_write(4'd5, 32'hCCCC_CCCC);
        command(mk_cmd(1'b1, S_NONE, 1023, 1'b0, 1'b1));
        command(mk_cmd(1'b1, S_NONE, 1023, 1'b1, 1'b0));
        bus_read(4'd5, r); check("R9 read with select 00 no load", r, 32'hCCCC_CCCC);
        command(mk_cmd(1'b1, S_SPI, 1023, 1'b1, 1'b0));
        bus_read(4'd5, r); check("R9 write with select 00 no store", r, 32'h0000_1234);
    endtask

    task automatic t_both_strobes();
        logic [31:0] r;
        bus_write(4'd11, 32'h1357_9BDF);
        command(mk_cmd(1'b1, S_KEY, 3, 1'b1, 1'b1));
        bus_read(4'd11, r); check("R10 no load on both strobes", r, 32'h1357_9BDF);
        bus_write(4'd11, 32'h0);
        command(mk_cmd(1'b1, S_KEY, 3, 1'b1, 1'b0));
        bus_read(4'd11, r); check("R10 write performed", r, 32'h1357_9BDF);
    endtask

    task automatic t_reset_keeps_tables();
        logic [31:0] r;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        bus_read(4'd5, r); check("R1 staging cleared by reset", r, 32'h0);
        check("R3 enable cleared by reset", 32'(lookup_en), 32'd0);
        command(mk_cmd(1'b0, S_SPI, 1023, 1'b1, 1'b0));
        bus_read(4'd5, r); check("R11 spi entry survives reset", r, 32'h0000_1234);
        command(mk_cmd(1'b0, S_KEY, 3, 1'b1, 1'b0));
        bus_read(4'd11, r); check("R11 key entry survives reset", r, 32'h1357_9BDF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_staging_regs();
        t_cmd_and_enable();
        t_addr_table();
        t_spi_table();
        t_key_table();
        t_out_of_range();
        t_select_none();
        t_both_strobes();
        t_reset_keeps_tables();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule